// File: doc/BRIEF.md
# Event-Timing Entropy Harvester

This block gathers seed material from the arrival times of asynchronous external events, such as a push button pressed by an operator. A fast counter runs on every clock from reset and is never touched by events or by software. Each event input first crosses into the clock domain through two flops. A filter then accepts a level change only after it has held steady for a programmable number of cycles. Each filtered rising edge is one event.

On each event the block samples the lowest few bits of the running counter and shifts them into a pool register. Only a handful of bits is taken per event, because the jitter in a human-timed event carries little true randomness beyond its lowest bits. A bit tally tracks how much of the pool is filled. When the pool is full, a ready flag rises. The pool contents can then load the seed port of a pseudo-random generator such as an LFSR. Further events are ignored until a clear empties the pool. The clear does not restart the running counter.

Top module: `event_entropy_harvester`

## Requirements
- R1: While reset is asserted and after it is released, poolData, bitCount and poolReady are all zero.
- R2: The free-running counter starts at zero when reset is released and increments on every clock edge after that. Neither events nor clearPool affect it.
- R3: The synchronized event level is taken as changed only after it has differed from the filtered level for debounceCycles consecutive clock samples, where a value of 0 counts as 1. A pulse held for fewer samples causes no capture.
- R4: Each filtered rising edge causes at most one capture. Suppose eventIn is first sampled high at edge P and stays high long enough, and let D be the effective debounce count. The capture then happens at edge P+D+2. It stores the low TAKE_BITS (default 2) bits of the free-running count as it stood after edge P+D+1.
- R5: A capture shifts poolData left by TAKE_BITS. The new bits enter at positions [TAKE_BITS-1:0], and the oldest bits leave from the MSB end.
- R6: Each capture adds TAKE_BITS to bitCount, which saturates at POOL_W (default 16). poolReady is 1 exactly when bitCount equals POOL_W.
- R7: While poolReady is 1, events leave poolData and bitCount unchanged.
- R8: clearPool sampled high sets poolData and bitCount to zero at that edge.
- R9: When clearPool is sampled at the same edge as a capture, the clear wins. That rising edge is discarded and no capture follows it later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eventIn | input | 1 | Raw asynchronous event line (for example a switch) |
| clearPool | input | 1 | Empties the pool and the bit tally |
| debounceCycles | input | DEB_W | Number of stable samples needed to accept a level change |
| poolData | output | POOL_W | Gathered entropy bits, newest at the LSB end |
| bitCount | output | $clog2(POOL_W+1) | Number of bits gathered since the last clear |
| poolReady | output | 1 | Pool full; further events are ignored |

## Verification
The bench predicts every captured value from its own edge count. A design with an extra or missing pipeline stage in the synchronizer or filter would therefore store wrong low-order bits, and the pool comparison would catch it. Pulses one sample shorter than the debounce setting probe the filter threshold; an off-by-one filter would capture them. Events arriving after the pool fills would corrupt the pool if the ready gate were missing. A clear placed exactly on a capture edge exposes wrong priority, or a rising edge that is remembered and captured afterwards. A capture after a clear checks that the running counter was not restarted.

// File: rtl/eh_pkg.sv
package eh_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic capture;  // take counter bits into the pool
    logic clear;    // empty the pool
  } ehStrobe_t;
endpackage

// File: rtl/eh_event_filter.sv
module eh_event_filter #(
  parameter int DEB_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eventIn,
  input  logic [DEB_W-1:0] debounceCycles,
  output logic             eventRise
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic                   stableLvl;
  logic                   prevLvl;
  logic [DEB_W-1:0]       debCnt;
  logic                   limitHit;

  assign syncLvl  = syncQ[SYNC_STAGES-1];
  assign limitHit = (debounceCycles <= DEB_W'(1)) ||
                    (debCnt == debounceCycles - DEB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ     <= '0;
      stableLvl <= 1'b0;
      prevLvl   <= 1'b0;
      debCnt    <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], eventIn};
      prevLvl <= stableLvl;
      if (syncLvl == stableLvl) begin
        debCnt <= '0;
      end else if (limitHit) begin
        stableLvl <= syncLvl;
        debCnt    <= '0;
      end else begin
        debCnt <= debCnt + DEB_W'(1);
      end
    end
  end

  assign eventRise = stableLvl & ~prevLvl;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eventRise |=> !eventRise); // R4
  AST_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stableLvl) |-> stableLvl == $past(syncLvl)); // R3
endmodule

// File: rtl/eh_ctrl.sv
module eh_ctrl
  import eh_pkg::*;
#(
  parameter int POOL_W    = 16,
  parameter int TAKE_BITS = 2,
  localparam int CNT_BITS = $clog2(POOL_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eventRise,
  input  logic                clearPool,
  output ehStrobe_t           strobe,
  output logic [CNT_BITS-1:0] bitCount,
  output logic                poolReady
);
  localparam int SUM_W = CNT_BITS + 1;

  logic [SUM_W-1:0]    bitSum;
  logic [CNT_BITS-1:0] bitNext;

  assign poolReady      = (bitCount >= CNT_BITS'(POOL_W));
  assign strobe.clear   = clearPool;
  assign strobe.capture = eventRise & ~poolReady & ~clearPool;

  assign bitSum  = {1'b0, bitCount} + SUM_W'(TAKE_BITS);
  assign bitNext = (bitSum > SUM_W'(POOL_W)) ? CNT_BITS'(POOL_W)
                                             : bitSum[CNT_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bitCount <= '0;
    else if (strobe.clear)   bitCount <= '0;
    else if (strobe.capture) bitCount <= bitNext;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitCount <= CNT_BITS'(POOL_W)); // R6
  AST_READY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    poolReady && !clearPool |=> $stable(bitCount) && poolReady); // R7
  AST_CLEAR_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    clearPool |=> bitCount == '0); // R8
  AST_RISE_DROPPED_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eventRise && clearPool |=> bitCount == '0 && !eventRise); // R9
endmodule

// File: rtl/eh_datapath.sv
module eh_datapath
  import eh_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int POOL_W    = 16,
  parameter int TAKE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ehStrobe_t         strobe,
  output logic [POOL_W-1:0] poolData
);
  logic [CNT_W-1:0]     freeCnt;
  logic [TAKE_BITS-1:0] sampleBits;
  logic [POOL_W-1:0]    poolShifted;

  assign sampleBits = freeCnt[TAKE_BITS-1:0];

  generate
    if (TAKE_BITS >= POOL_W) begin : g_whole
      assign poolShifted = sampleBits[POOL_W-1:0];
    end else begin : g_shift
      assign poolShifted = {poolData[POOL_W-TAKE_BITS-1:0], sampleBits};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freeCnt <= '0;
    else        freeCnt <= freeCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              poolData <= '0;
    else if (strobe.clear)   poolData <= '0;
    else if (strobe.capture) poolData <= poolShifted;
  end

  AST_FREE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(freeCnt) |=> freeCnt == $past(freeCnt) + CNT_W'(1)); // R2
  AST_NEW_BITS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> poolData[TAKE_BITS-1:0] == $past(freeCnt[TAKE_BITS-1:0])); // R5
  AST_CLEAR_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> poolData == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture && !strobe.clear |=> $stable(poolData)); // R7
endmodule

// File: rtl/event_entropy_harvester.sv
module event_entropy_harvester
  import eh_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int POOL_W    = 16,
  parameter int TAKE_BITS = 2,
  parameter int DEB_W     = 8,
  localparam int CNT_BITS = $clog2(POOL_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eventIn,
  input  logic                clearPool,
  input  logic [DEB_W-1:0]    debounceCycles,
  output logic [POOL_W-1:0]   poolData,
  output logic [CNT_BITS-1:0] bitCount,
  output logic                poolReady
);
  logic      eventRise;
  ehStrobe_t strobe;

  eh_event_filter #(.DEB_W(DEB_W), .SYNC_STAGES(2)) u_filter (
    .clk(clk), .rst_n(rst_n), .eventIn(eventIn),
    .debounceCycles(debounceCycles), .eventRise(eventRise)
  );

  eh_ctrl #(.POOL_W(POOL_W), .TAKE_BITS(TAKE_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .eventRise(eventRise), .clearPool(clearPool),
    .strobe(strobe), .bitCount(bitCount), .poolReady(poolReady)
  );

  eh_datapath #(.CNT_W(CNT_W), .POOL_W(POOL_W), .TAKE_BITS(TAKE_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .poolData(poolData)
  );

  AST_READY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    poolReady == (bitCount == CNT_BITS'(POOL_W))); // R6
endmodule

// File: tb/tb_event_entropy_harvester.sv
`timescale 1ns/1ps
module tb_event_entropy_harvester;
  localparam int POOL_W = 16;
  localparam int TAKE   = 2;
  localparam int NVEC   = 11;
  // deb, hold, gap
  localparam int VEC [NVEC][3] = '{
    '{3,5,12}, '{1,1,12}, '{2,1,12}, '{4,6,14}, '{2,3,12}, '{3,2,12},
    '{1,2,12}, '{5,5,14}, '{2,4,12}, '{3,3,12}, '{1,3,12}};

  logic clk = 0, rst_n = 0, eventIn = 0, clearPool = 0;
  logic [7:0] debounceCycles = 8'd3;
  logic [POOL_W-1:0] poolData;
  logic [4:0] bitCount;
  logic poolReady;
  int checks = 0, errors = 0, posCount = 0, wd = 0;
  int modelPool = 0, modelCnt = 0;

  event_entropy_harvester dut (
    .clk(clk), .rst_n(rst_n), .eventIn(eventIn), .clearPool(clearPool),
    .debounceCycles(debounceCycles), .poolData(poolData),
    .bitCount(bitCount), .poolReady(poolReady));

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) posCount <= posCount + 1;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, poolData, modelPool);
    check(req, bitCount, modelCnt);
    check(req, poolReady, modelCnt == POOL_W);
  endtask

  // One event pulse; updates the model if a capture is expected
  task automatic pulse(int deb, int hold, int gap);
    int dEff, capVal;
    @(negedge clk);
    debounceCycles = 8'(deb);
    dEff = (deb < 1) ? 1 : deb;
    capVal = posCount + 2 + dEff;       // R4 latency
    eventIn = 1;
    repeat (hold) @(negedge clk);
    eventIn = 0;
    repeat (gap) @(negedge clk);
    if (hold >= dEff && modelCnt < POOL_W) begin   // R3, R7
      modelPool = ((modelPool << TAKE) | (capVal & ((1 << TAKE) - 1))) & 16'hFFFF; // R5
      modelCnt += TAKE;                              // R6
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checkAll("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    checkAll("R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][0], VEC[i][1], VEC[i][2]);
      checkAll("R3/R4/R5/R6/R7 vector");
    end
    check("R6 ready after fill", poolReady, 1);

    pulse(2, 4, 12);
    checkAll("R7 event while ready");

    @(negedge clk); clearPool = 1;
    @(negedge clk); clearPool = 0;
    modelPool = 0; modelCnt = 0;
    checkAll("R8 clear");

    pulse(2, 3, 12);
    checkAll("R2 counter kept running after clear");

    // R9: clear lands on the capture edge
    begin
      int n;
      @(negedge clk);
      debounceCycles = 8'd2;
      n = posCount;
      eventIn = 1;
      while (posCount < n + 2 + 2) @(negedge clk);
      clearPool = 1;
      @(negedge clk);
      clearPool = 0;
      eventIn = 0;
      modelPool = 0; modelCnt = 0;
      checkAll("R9 clear beats capture");
      repeat (12) @(negedge clk);
      checkAll("R9 no late capture");
    end

    pulse(0, 1, 12);
    checkAll("R3 zero debounce acts as one");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule